// File: doc/BRIEF.md
# Amplitude-Binned TAC Slew Corrector

This block corrects timing readings on a 32-channel front-end board for amplitude walk. Each incoming sample carries a channel number, a pedestal-subtracted 12-bit ADC amplitude and a 12-bit TAC value. The block sorts the amplitude into one of eight bins using that channel's own upper limits. It then adds the bin's signed offset to the TAC value, clamps the result to the 12-bit range and hands the sample on to the channel-mask stage downstream.

Only channels whose index has bit 2 set (4–7, 12–15, 20–23, 28–31) carry timing data. Storage exists only for those sixteen channels. Samples on the other channels leave with their TAC untouched. A write port loads one limit or one offset per cycle. A write aimed at a channel without timing data changes nothing and raises a one-cycle error pulse.

The datapath has two register stages and a valid/ready handshake. A stall at the output freezes both stages.

Top module: `slew_corrector`

## Requirements
- R1: After reset every limit is 4095 and every offset is 0, so any sample leaves with its TAC unchanged. `out_valid` and `cfg_err` are low and `in_ready` is high.
- R2: On a timing channel the amplitude selects bin N when limit N-1 < ADC <= limit N, with an implied lower bound of 0. An ADC value of 0 therefore selects bin 0.
- R3: When several limits are equal, the lowest-numbered bin whose limit is at least the ADC value is used.
- R4: If the ADC value exceeds every limit of the channel, bin 7 is used.
- R5: Offsets are 9-bit two's complement taken from `cfg_data[8:0]`, covering -256 to +255, and are added to the TAC value.
- R6: The corrected TAC saturates at 0 below and at 4095 above; it never wraps.
- R7: A sample on a channel whose index bit 2 is 0 leaves with its TAC unchanged.
- R8: A write with `cfg_ch` bit 2 equal to 0 changes no stored value. `cfg_err` is high in the cycle after such a write and low after any other cycle.
- R9: A sample accepted at clock edge k appears on the outputs after edge k+1, with its channel and ADC value carried unchanged. Back-to-back samples stream at one per cycle.
- R10: While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low.
- R11: A write selects the value with `cfg_sel` (0 = bin limit, 1 = offset), `cfg_ch` and `cfg_bin`. It affects only that one channel and bin, and takes effect for samples accepted from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 5 | Channel index of the write |
| cfg_bin | input | 3 | Bin index of the write |
| cfg_sel | input | 1 | 0 writes a bin limit, 1 writes an offset |
| cfg_data | input | 12 | Limit value, or offset in bits 8:0 |
| cfg_err | output | 1 | Pulse: the previous write targeted a channel without timing data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_ch | input | 5 | Input channel index |
| in_adc | input | 12 | Pedestal-subtracted amplitude |
| in_tac | input | 12 | TAC value to correct |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_ch | output | 5 | Channel index, carried through |
| out_adc | output | 12 | Amplitude, carried through |
| out_tac | output | 12 | Corrected, clamped TAC value |

## Verification
The bench builds the block with its default parameters: 32 channels, eight bins, 12-bit ADC and TAC, 9-bit offsets and bit 2 as the timing-channel marker. At these values the exact limit values seen on real boards (30 up to 4095) can be loaded. Both clamp rails are reachable with the largest positive and negative offsets. The aliasing case can also be probed: channel 3 maps onto the same storage slot as channel 7, so a write to channel 3 that leaked through would show up on channel 7's samples.

// File: rtl/slew_pkg.sv
// Package: shared constants and types for the slew corrector.
// Assumes: offsets are narrower than the TAC word plus two guard bits.
package slew_pkg;

    // Selector for the configuration write target.
    typedef enum logic {
        CFG_LIMIT  = 1'b0,
        CFG_OFFSET = 1'b1
    } cfg_target_e;

endpackage

// File: rtl/slew_cfg_store.sv
// Module: slew_cfg_store
// Holds the bin upper limits and signed offsets for every timing channel.
// Only channels with index bit TAC_BIT set own a storage slot. The slot
// number is the channel index with that bit removed. One row (all bins of
// one slot) is read combinationally. Assumes 0 < TAC_BIT < CH_W-1.
module slew_cfg_store #(
    parameter int CH_W     = 5,
    parameter int BIN_W    = 3,
    parameter int ADC_W    = 12,
    parameter int OFS_W    = 9,
    parameter int TAC_BIT  = 2,
    localparam int NUM_BINS = 1 << BIN_W,
    localparam int SLOT_W   = CH_W - 1,
    localparam int NUM_SLOT = 1 << SLOT_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [CH_W-1:0]                    wr_ch,
    input  logic [BIN_W-1:0]                   wr_bin,
    input  slew_pkg::cfg_target_e              wr_sel,
    input  logic [ADC_W-1:0]                   wr_data,
    input  logic [CH_W-1:0]                    rd_ch,
    output logic [NUM_BINS-1:0][ADC_W-1:0]     rd_lim,
    output logic [NUM_BINS-1:0][OFS_W-1:0]     rd_ofs
);

    logic [NUM_SLOT-1:0][NUM_BINS-1:0][ADC_W-1:0] lim_q;
    logic [NUM_SLOT-1:0][NUM_BINS-1:0][OFS_W-1:0] ofs_q;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic              wr_ok;

    // Compress channel indices into slot numbers by dropping the marker bit.
    always_comb begin
        wr_slot = {wr_ch[CH_W-1:TAC_BIT+1], wr_ch[TAC_BIT-1:0]};
        rd_slot = {rd_ch[CH_W-1:TAC_BIT+1], rd_ch[TAC_BIT-1:0]};
        wr_ok   = wr_en && wr_ch[TAC_BIT];
    end

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        // Per-slot registers: reset to full-range limits and zero offsets.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int b = 0; b < NUM_BINS; b++) begin
                    lim_q[g][b] <= '1;
                    ofs_q[g][b] <= '0;
                end
            end else if (wr_ok && (wr_slot == SLOT_W'(g))) begin
                if (wr_sel == slew_pkg::CFG_LIMIT)
                    lim_q[g][wr_bin] <= wr_data;
                else
                    ofs_q[g][wr_bin] <= wr_data[OFS_W-1:0];
            end
        end
    end

    // Present the row of the channel being looked up.
    always_comb begin
        rd_lim = lim_q[rd_slot];
        rd_ofs = ofs_q[rd_slot];
    end

endmodule

// File: rtl/slew_bin_search.sv
// Module: slew_bin_search
// Picks the lowest bin whose inclusive upper limit is at or above the
// amplitude. Falls back to the last bin when no limit qualifies. Purely
// combinational. Assumes nothing about limit ordering.
module slew_bin_search #(
    parameter int BIN_W = 3,
    parameter int ADC_W = 12,
    localparam int NUM_BINS = 1 << BIN_W
) (
    input  logic [ADC_W-1:0]               adc,
    input  logic [NUM_BINS-1:0][ADC_W-1:0] lim,
    output logic [BIN_W-1:0]               bin
);

    logic [NUM_BINS-1:0] hit;

    // Compare the amplitude against every limit in parallel.
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_cmp
        assign hit[b] = (adc <= lim[b]);
    end

    // Priority pick: scanning downward leaves the lowest hit in place.
    always_comb begin
        bin = BIN_W'(NUM_BINS - 1);
        for (int b = NUM_BINS - 1; b >= 0; b--) begin
            if (hit[b]) bin = BIN_W'(b);
        end
    end

endmodule

// File: rtl/slew_sat_add.sv
// Module: slew_sat_add
// Adds a signed offset to an unsigned TAC value and saturates the result
// to [0, 2**TAC_W-1]. Combinational. Assumes OFS_W <= TAC_W + 1.
module slew_sat_add #(
    parameter int TAC_W = 12,
    parameter int OFS_W = 9,
    localparam int SUM_W = TAC_W + 2
) (
    input  logic [TAC_W-1:0] tac,
    input  logic [OFS_W-1:0] ofs,
    output logic [TAC_W-1:0] res
);

    logic signed [SUM_W-1:0] sum;

    // Widen both operands and add with two guard bits.
    always_comb begin
        sum = $signed({2'b00, tac}) + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    end

    // Clamp: a set sign bit is an underflow, a set carry bit an overflow.
    always_comb begin
        if (sum[SUM_W-1])
            res = '0;
        else if (sum[TAC_W])
            res = '1;
        else
            res = sum[TAC_W-1:0];
    end

endmodule

// File: rtl/slew_corrector.sv
// Module: slew_corrector (top)
// Two-stage amplitude-binned TAC slew correction with a valid/ready handshake.
// Stage 1 looks up the channel row, finds the bin and registers the chosen
// offset with the sample. Stage 2 adds and clamps, then presents the result.
// A stall at the output freezes both stages. Non-timing channels get a zero
// offset. Configuration writes to non-timing channels pulse cfg_err.
module slew_corrector #(
    parameter int NUM_CH  = 32,
    parameter int NUM_BIN = 8,
    parameter int ADC_W   = 12,
    parameter int TAC_W   = 12,
    parameter int OFS_W   = 9,
    parameter int TAC_BIT = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BIN_W  = $clog2(NUM_BIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic [BIN_W-1:0] cfg_bin,
    input  logic             cfg_sel,
    input  logic [ADC_W-1:0] cfg_data,
    output logic             cfg_err,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CH_W-1:0]  in_ch,
    input  logic [ADC_W-1:0] in_adc,
    input  logic [TAC_W-1:0] in_tac,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CH_W-1:0]  out_ch,
    output logic [ADC_W-1:0] out_adc,
    output logic [TAC_W-1:0] out_tac
);

    logic [NUM_BIN-1:0][ADC_W-1:0] row_lim;
    logic [NUM_BIN-1:0][OFS_W-1:0] row_ofs;
    logic [BIN_W-1:0]              bin_sel;
    logic [OFS_W-1:0]              ofs_d;
    logic                          adv;

    logic             s1_valid;
    logic [CH_W-1:0]  s1_ch;
    logic [ADC_W-1:0] s1_adc;
    logic [TAC_W-1:0] s1_tac;
    logic [OFS_W-1:0] s1_ofs;
    logic [TAC_W-1:0] s2_tac_d;

    slew_cfg_store #(
        .CH_W    (CH_W),
        .BIN_W   (BIN_W),
        .ADC_W   (ADC_W),
        .OFS_W   (OFS_W),
        .TAC_BIT (TAC_BIT)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_ch   (cfg_ch),
        .wr_bin  (cfg_bin),
        .wr_sel  (slew_pkg::cfg_target_e'(cfg_sel)),
        .wr_data (cfg_data),
        .rd_ch   (in_ch),
        .rd_lim  (row_lim),
        .rd_ofs  (row_ofs)
    );

    slew_bin_search #(
        .BIN_W (BIN_W),
        .ADC_W (ADC_W)
    ) u_search (
        .adc (in_adc),
        .lim (row_lim),
        .bin (bin_sel)
    );

    slew_sat_add #(
        .TAC_W (TAC_W),
        .OFS_W (OFS_W)
    ) u_add (
        .tac (s1_tac),
        .ofs (s1_ofs),
        .res (s2_tac_d)
    );

    // Pipeline advance: move whenever the output slot is free or draining.
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv;
        ofs_d    = in_ch[TAC_BIT] ? row_ofs[bin_sel] : '0;
    end

    // Stage 1: capture the sample and its selected offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_ch    <= '0;
            s1_adc   <= '0;
            s1_tac   <= '0;
            s1_ofs   <= '0;
        end else if (adv) begin
            s1_valid <= in_valid;
            s1_ch    <= in_ch;
            s1_adc   <= in_adc;
            s1_tac   <= in_tac;
            s1_ofs   <= ofs_d;
        end
    end

    // Stage 2: register the clamped sum as the output sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_adc   <= '0;
            out_tac   <= '0;
        end else if (adv) begin
            out_valid <= s1_valid;
            out_ch    <= s1_ch;
            out_adc   <= s1_adc;
            out_tac   <= s2_tac_d;
        end
    end

    // Error pulse: flag a write aimed at a channel without timing data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else
            cfg_err <= cfg_we && !cfg_ch[TAC_BIT];
    end

endmodule

// File: rtl/slew_corrector_chk.sv
// Module: slew_corrector_chk
// Port-level temporal checks for slew_corrector, attached by bind.
module slew_corrector_chk #(
    parameter int CH_W    = 5,
    parameter int ADC_W   = 12,
    parameter int TAC_W   = 12,
    parameter int TAC_BIT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CH_W-1:0]  cfg_ch,
    input logic             cfg_err,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CH_W-1:0]  out_ch,
    input logic [ADC_W-1:0] out_adc,
    input logic [TAC_W-1:0] out_tac
);

    // R10: a stalled output keeps its sample unchanged.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tac) && $stable(out_ch) && $stable(out_adc)));

    // R10: a stalled output blocks the input.
    a_r10_in_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: an empty output slot always accepts input.
    a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R8: an error pulse is caused by a write to a non-timing channel.
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($past(cfg_we) && !$past(cfg_ch[TAC_BIT])));

    // R8: no write means no error in the next cycle.
    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> !cfg_err);

endmodule

bind slew_corrector slew_corrector_chk #(
    .CH_W    (CH_W),
    .ADC_W   (ADC_W),
    .TAC_W   (TAC_W),
    .TAC_BIT (TAC_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_err   (cfg_err),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ch    (out_ch),
    .out_adc   (out_adc),
    .out_tac   (out_tac)
);

// File: tb/test_slew_corrector.sv
// Directed bench for slew_corrector; one task per scenario.
module test_slew_corrector;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_ch;
    logic [2:0]  cfg_bin;
    logic        cfg_sel;
    logic [11:0] cfg_data;
    logic        cfg_err;
    logic        in_valid;
    logic        in_ready;
    logic [4:0]  in_ch;
    logic [11:0] in_adc;
    logic [11:0] in_tac;
    logic        out_valid;
    logic        out_ready;
    logic [4:0]  out_ch;
    logic [11:0] out_adc;
    logic [11:0] out_tac;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_lim [32][8];
    int m_ofs [32][8];

    always #2.5 clk = ~clk;

    slew_corrector i_slew_corrector (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_bin(cfg_bin), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_ch(in_ch),
        .in_adc(in_adc), .in_tac(in_tac),
        .out_valid(out_valid), .out_ready(out_ready), .out_ch(out_ch),
        .out_adc(out_adc), .out_tac(out_tac)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int ch, input int adc, input int tac);
        int b;
        int v;
        if (((ch >> 2) & 1) == 0) return tac;
        b = 7;
        for (int i = 7; i >= 0; i--) if (adc <= m_lim[ch][i]) b = i;
        v = tac + m_ofs[ch][b];
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    // One configuration write; checks the error pulse after it.
    task automatic cfg_write(input int ch, input int bin, input int sel, input int val);
        @(negedge clk);
        cfg_we = 1; cfg_ch = 5'(ch); cfg_bin = 3'(bin); cfg_sel = sel[0];
        cfg_data = (sel != 0) ? 12'(val & 'h1FF) : 12'(val);
        @(negedge clk);
        cfg_we = 0;
        check("R8 err pulse", int'(cfg_err), (((ch >> 2) & 1) == 0) ? 1 : 0);
        if (((ch >> 2) & 1) != 0) begin
            if (sel != 0) m_ofs[ch][bin] = val;
            else m_lim[ch][bin] = val;
        end
    endtask

    // One isolated sample; checks it two edges later.
    task automatic send(input string req, input int ch, input int adc, input int tac);
        @(negedge clk);
        in_valid = 1; in_ch = 5'(ch); in_adc = 12'(adc); in_tac = 12'(tac);
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        check(req, int'(out_valid), 1);
        check(req, int'(out_tac), model(ch, adc, tac));
    endtask

    task automatic load_row(input int ch, input int lim[8], input int ofs[8]);
        for (int i = 0; i < 8; i++) begin
            cfg_write(ch, i, 0, lim[i]);
            cfg_write(ch, i, 1, ofs[i]);
        end
    endtask

    task automatic t_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        check("R1 in_ready", int'(in_ready), 1);
        send("R1 default passthrough", 5, 50, 1000);
        send("R1 default passthrough", 31, 4095, 7);
    endtask

    task automatic t_bins();
        load_row(5, '{30, 60, 95, 135, 200, 300, 600, 4095},
                    '{112, 64, 37, 18, 4, -9, -26, -50});
        send("R2 adc0 bin0", 5, 0, 2000);
        send("R2 at limit0", 5, 30, 2000);
        send("R2 above limit0", 5, 31, 2000);
        send("R2 at limit6", 5, 600, 2000);
        send("R2 above limit6", 5, 601, 2000);
        send("R5 negative offset", 5, 250, 500);
        send("R11 other channel untouched", 6, 31, 2000);
    endtask

    task automatic t_equal();
        load_row(12, '{100, 100, 100, 200, 300, 400, 500, 4095},
                     '{10, 20, 30, 40, 50, 60, 70, 80});
        send("R3 equal limits lowest", 12, 100, 1000);
        send("R3 just above equal run", 12, 101, 1000);
    endtask

    task automatic t_over();
        load_row(13, '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000},
                     '{1, 2, 3, 4, 5, 6, 7, -5});
        send("R4 above all limits", 13, 2000, 1000);
        send("R4 at top limit", 13, 1000, 1000);
    endtask

    task automatic t_clamp();
        send("R6 clamp high", 5, 10, 4050);
        send("R6 clamp low", 5, 4095, 20);
        cfg_write(14, 0, 1, 255);
        cfg_write(14, 1, 1, -256);
        cfg_write(14, 0, 0, 10);
        send("R5 max offset", 14, 5, 100);
        send("R5 min offset", 14, 11, 1000);
        send("R6 clamp max offset", 14, 5, 3900);
        send("R6 clamp min offset", 14, 11, 200);
    endtask

    task automatic t_nontac();
        cfg_write(3, 0, 1, 100);
        cfg_write(3, 0, 0, 0);
        send("R8 write to ch3 ignored (ch7)", 7, 0, 1234);
        send("R7 non-timing passthrough", 3, 0, 1234);
        send("R7 non-timing passthrough", 16, 4000, 3);
    endtask

    task automatic t_stream();
        int chs[6]  = '{5, 3, 12, 13, 5, 14};
        int adcs[6] = '{0, 9, 100, 2000, 601, 11};
        int tacs[6] = '{10, 20, 3000, 40, 4095, 600};
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                check("R9 stream valid", int'(out_valid), 1);
                check("R9 stream ch", int'(out_ch), chs[n-2]);
                check("R9 stream adc", int'(out_adc), adcs[n-2]);
                check("R9 stream tac", int'(out_tac), model(chs[n-2], adcs[n-2], tacs[n-2]));
            end
            if (n < 6) begin
                in_valid = 1; in_ch = 5'(chs[n]); in_adc = 12'(adcs[n]); in_tac = 12'(tacs[n]);
            end else in_valid = 0;
        end
        @(negedge clk);
        check("R9 drained", int'(out_valid), 0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 0;
        in_valid = 1; in_ch = 5; in_adc = 0; in_tac = 100;
        @(negedge clk);
        check("R10 ready while filling", int'(in_ready), 1);
        in_ch = 12; in_adc = 101; in_tac = 200;
        @(negedge clk);
        in_valid = 0;
        for (int k = 0; k < 3; k++) begin
            check("R10 held valid", int'(out_valid), 1);
            check("R10 held tac", int'(out_tac), model(5, 0, 100));
            check("R10 in_ready low", int'(in_ready), 0);
            @(negedge clk);
        end
        out_ready = 1;
        @(negedge clk);
        check("R10 second after release", int'(out_tac), model(12, 101, 200));
        check("R10 second ch", int'(out_ch), 12);
        @(negedge clk);
        check("R10 empty after drain", int'(out_valid), 0);
    endtask

    initial begin
        for (int c = 0; c < 32; c++)
            for (int b = 0; b < 8; b++) begin
                m_lim[c][b] = 4095;
                m_ofs[c][b] = 0;
            end
        rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_bin = 0; cfg_sel = 0; cfg_data = 0;
        in_valid = 0; in_ch = 0; in_adc = 0; in_tac = 0; out_ready = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bins();
        t_equal();
        t_over();
        t_clamp();
        t_nontac();
        t_stream();
        t_stall();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule